// File: doc/BRIEF.md
# Edge-Event GPIO Controller

This block is a memory-mapped general purpose I/O controller for a configurable number of pins, up to the width of its 32-bit register bus. Software drives pins by setting and clearing output-enable and output-data bits through two write-only windows. One window sets bits and the other clears them, so no read-modify-write is needed. A main window holds the per-pin edge enables and returns the synchronized input levels.

Each pin input passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one cycle earlier. An enabled rising or falling edge latches a bit in a cause register. A cause window holds an event mask, a masked view of the pending causes, and a write-one-to-clear port. The enabled causes are ORed into one shared, level-style interrupt line.

Top module: `pin_event_gpio`

## Requirements
- R1: The pin count is the parameter `PIN_COUNT` (at most 32). Register bits at or above `PIN_COUNT` read as zero, and written ones in those positions change nothing.
- R2: The bus window select is encoded as 0 = main, 1 = cause, 2 = set, 3 = clear. In the set window, a write at byte offset 0x00 sets each output-enable bit whose data bit is one. A write at offset 0x04 sets output-data bits in the same way.
- R3: In the clear window, a write at offset 0x00 clears each output-enable bit whose data bit is one. A write at offset 0x04 clears output-data bits in the same way. Zero data bits leave the stored bits unchanged.
- R4: `pinOe` equals the output-enable register. `pinOut` equals the output-data bit where the enable is one and is 0 elsewhere, so the pad is released whenever its enable is low.
- R5: In the main window, offset 0x00 is the read/write rising-edge enable and offset 0x04 is the read/write falling-edge enable. Offset 0x08 reads the pin levels after a two-stage synchronizer. The set and clear windows read as zero, and writes to read-only or unused offsets have no effect.
- R6: A cause bit is set by a rising edge when its rising enable is one, and by a falling edge when its falling enable is one. With both enables set, the pin reports both edges. A steady level sets nothing, and an edge whose enable is zero sets nothing.
- R7: In the cause window, offset 0x14 is the read/write event mask. Offset 0x00 reads the cause bits ANDed with the mask. A cause bit latches whether or not its mask bit is set.
- R8: A write at cause-window offset 0x18 clears each cause bit whose data bit is one and leaves the others. Writing all ones clears every pending cause.
- R9: If an enabled edge on a pin arrives in the same cycle as a clear write for that pin's cause bit, the bit stays set.
- R10: `irqOut` is the OR of all cause bits whose mask bit is one. It stays high until those bits are cleared or masked off.
- R11: Reset (active-low `rstN`) clears the output enable, output data, both edge enables, the mask and all cause bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWinSel | input | 2 | Register window: 0 main, 1 cause, 2 set, 3 clear |
| busAddr | input | ADDR_W | Byte offset within the window |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busWrData | input | BUS_W | Write data |
| busRdData | output | BUS_W | Read data for the addressed register, combinational |
| pinIn | input | PIN_COUNT | Asynchronous pin levels |
| pinOut | output | PIN_COUNT | Driven pin values (0 where not enabled) |
| pinOe | output | PIN_COUNT | Per-pin output enable |
| irqOut | output | 1 | Shared interrupt, OR of masked causes |

## Verification
The bench builds the block with `PIN_COUNT` = 24, the narrower of the two sizes in use. At that size the eight upper bus bits lie beyond the pins, so the bench can show that they read as zero after all-ones writes to the enables and the mask. Pin patterns whose upper byte toggles show that edges in the upper pins land in the right cause positions. A clear write is timed to land in the exact cycle an edge is detected, to show that the edge wins.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  typedef enum logic [1:0] {
    WIN_MAIN  = 2'd0,
    WIN_CAUSE = 2'd1,
    WIN_SET   = 2'd2,
    WIN_CLR   = 2'd3
  } win_e;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_RISE,
    RD_FALL,
    RD_PINS,
    RD_PEND,
    RD_MASK
  } rdSel_e;

  // Write strobes from decode to datapath; at most one is active per cycle.
  typedef struct packed {
    logic oeSet;
    logic oeClr;
    logic doSet;
    logic doClr;
    logic riseWr;
    logic fallWr;
    logic maskWr;
    logic causeClr;
  } strobes_t;

  localparam int OFS_OE    = 'h00;
  localparam int OFS_DO    = 'h04;
  localparam int OFS_RISE  = 'h00;
  localparam int OFS_FALL  = 'h04;
  localparam int OFS_PINS  = 'h08;
  localparam int OFS_PEND  = 'h00;
  localparam int OFS_MASK  = 'h14;
  localparam int OFS_CLEAR = 'h18;

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain[0] <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[LAST];

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busWinSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobes_t          stb,
  output rdSel_e            rdSel
);

  win_e win;
  assign win = win_e'(busWinSel);

  always_comb begin
    stb   = '0;
    rdSel = RD_ZERO;
    case (win)
      WIN_SET: begin
        if (busAddr == ADDR_W'(OFS_OE)) stb.oeSet = busWrEn;
        if (busAddr == ADDR_W'(OFS_DO)) stb.doSet = busWrEn;
      end
      WIN_CLR: begin
        if (busAddr == ADDR_W'(OFS_OE)) stb.oeClr = busWrEn;
        if (busAddr == ADDR_W'(OFS_DO)) stb.doClr = busWrEn;
      end
      WIN_MAIN: begin
        if (busAddr == ADDR_W'(OFS_RISE)) begin
          stb.riseWr = busWrEn;
          rdSel      = RD_RISE;
        end else if (busAddr == ADDR_W'(OFS_FALL)) begin
          stb.fallWr = busWrEn;
          rdSel      = RD_FALL;
        end else if (busAddr == ADDR_W'(OFS_PINS)) begin
          rdSel      = RD_PINS;
        end
      end
      WIN_CAUSE: begin
        if (busAddr == ADDR_W'(OFS_PEND)) begin
          rdSel        = RD_PEND;
        end else if (busAddr == ADDR_W'(OFS_MASK)) begin
          stb.maskWr   = busWrEn;
          rdSel        = RD_MASK;
        end else if (busAddr == ADDR_W'(OFS_CLEAR)) begin
          stb.causeClr = busWrEn;
        end
      end
      default: ;
    endcase
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)) else $error("more than one write strobe");  // R5
  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> stb == '0) else $error("strobe without write");  // R5

endmodule

// File: rtl/gpio_evt_dp.sv
module gpio_evt_dp
  import gpio_evt_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic              irqOut
);

  localparam int SYNC_STAGES = 2;

  logic [PINS-1:0] wrBits;
  logic [PINS-1:0] oeReg, doReg, riseEn, fallEn, maskReg, causeReg;
  logic [PINS-1:0] pinSync, pinPrev;
  logic [PINS-1:0] riseHits, fallHits, edgeHits, clrBits;
  logic [PINS-1:0] rdNarrow;

  assign wrBits = wrData[PINS-1:0];

  // Output control registers: set and clear arrive through separate strobes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeReg <= '0;
      doReg <= '0;
    end else begin
      if (stb.oeSet) oeReg <= oeReg | wrBits;
      if (stb.oeClr) oeReg <= oeReg & ~wrBits;
      if (stb.doSet) doReg <= doReg | wrBits;
      if (stb.doClr) doReg <= doReg & ~wrBits;
    end
  end

  assign pinOe  = oeReg;
  assign pinOut = doReg & oeReg;

  // Edge and mask configuration.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseEn  <= '0;
      fallEn  <= '0;
      maskReg <= '0;
    end else begin
      if (stb.riseWr) riseEn  <= wrBits;
      if (stb.fallWr) fallEn  <= wrBits;
      if (stb.maskWr) maskReg <= wrBits;
    end
  end

  gpio_evt_sync #(
    .WIDTH  (PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;
  end

  assign riseHits = pinSync & ~pinPrev & riseEn;
  assign fallHits = ~pinSync & pinPrev & fallEn;
  assign edgeHits = riseHits | fallHits;
  assign clrBits  = stb.causeClr ? wrBits : '0;

  // Clear first, then merge new edges so a same-cycle edge survives.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) causeReg <= '0;
    else       causeReg <= (causeReg & ~clrBits) | edgeHits;
  end

  assign irqOut = |(causeReg & maskReg);

  always_comb begin
    case (rdSel)
      RD_RISE: rdNarrow = riseEn;
      RD_FALL: rdNarrow = fallEn;
      RD_PINS: rdNarrow = pinSync;
      RD_PEND: rdNarrow = causeReg & maskReg;
      RD_MASK: rdNarrow = maskReg;
      default: rdNarrow = '0;
    endcase
    rdData = '0;
    rdData[PINS-1:0] = rdNarrow;
  end

  AST_OE_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.oeSet |=> (oeReg & $past(wrBits)) == $past(wrBits)) else $error("oe set lost");  // R2
  AST_DO_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.doSet |=> (doReg & $past(wrBits)) == $past(wrBits)) else $error("data set lost");  // R2
  AST_OE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    stb.oeClr |=> (oeReg & $past(wrBits)) == '0) else $error("oe clear lost");  // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.causeClr && (edgeHits & wrBits) == '0) |=> (causeReg & $past(wrBits)) == '0)
    else $error("cause clear lost");  // R8
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (edgeHits != '0) |=> (causeReg & $past(edgeHits)) == $past(edgeHits))
    else $error("edge not latched");  // R9
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.causeClr && edgeHits == '0) |=> $stable(causeReg))
    else $error("cause changed without edge");  // R6
  AST_NO_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinOe[0]) |-> !pinOut[0]) else $error("pin driven while released");  // R4

endmodule

// File: rtl/pin_event_gpio.sv
module pin_event_gpio
  import gpio_evt_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           busWinSel,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [BUS_W-1:0]     busWrData,
  output logic [BUS_W-1:0]     busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);

  strobes_t stb;
  rdSel_e   rdSel;

  gpio_evt_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWinSel (busWinSel),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .stb       (stb),
    .rdSel     (rdSel)
  );

  gpio_evt_dp #(
    .PINS   (PIN_COUNT),
    .DATA_W (BUS_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rdSel  (rdSel),
    .wrData (busWrData),
    .rdData (busRdData),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqOut (irqOut)
  );

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busWinSel == 2'd1 && busAddr == ADDR_W'('h14) && busWrData == '0) |=> !irqOut)
    else $error("irq with empty mask");  // R10

endmodule

// File: tb/sim_pin_event_gpio.sv
module sim_pin_event_gpio;

  localparam int PINS = 24;
  localparam int NVEC = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busWinSel = '0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] pinOut, pinOe;
  logic        irqOut;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pin_event_gpio #(.PIN_COUNT(PINS), .BUS_W(32), .ADDR_W(5)) u0 (
    .clk(clk), .rstN(rstN), .busWinSel(busWinSel), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        isWr;
    logic [1:0]  win;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] expRd;
    logic [23:0] expOe;
    logic [23:0] expOut;
    logic [7:0]  req;
  } vec_t;

  // Windows: 0 main, 1 cause, 2 set, 3 clear.
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 2'd2, 5'h00, 32'h00FF_00F0, 32'h0, 24'hFF00F0, 24'h000000, 8'd2},  // R2
    '{1'b1, 2'd2, 5'h04, 32'h0000_0FFF, 32'h0, 24'hFF00F0, 24'h0000F0, 8'd4},  // R4
    '{1'b1, 2'd3, 5'h00, 32'h0000_0030, 32'h0, 24'hFF00C0, 24'h0000C0, 8'd3},  // R3
    '{1'b1, 2'd3, 5'h04, 32'h0000_0F0F, 32'h0, 24'hFF00C0, 24'h0000C0, 8'd3},  // R3
    '{1'b1, 2'd0, 5'h00, 32'hFFFF_0005, 32'h0, 24'hFF00C0, 24'h0000C0, 8'd5},  // R5
    '{1'b0, 2'd0, 5'h00, 32'h0,         32'h00FF_0005, 24'hFF00C0, 24'h0000C0, 8'd1},  // R1
    '{1'b1, 2'd0, 5'h04, 32'h0000_0006, 32'h0, 24'hFF00C0, 24'h0000C0, 8'd5},  // R5
    '{1'b0, 2'd0, 5'h04, 32'h0,         32'h0000_0006, 24'hFF00C0, 24'h0000C0, 8'd5},  // R5
    '{1'b1, 2'd1, 5'h14, 32'hFFFF_FFFF, 32'h0, 24'hFF00C0, 24'h0000C0, 8'd7},  // R7
    '{1'b0, 2'd1, 5'h14, 32'h0,         32'h00FF_FFFF, 24'hFF00C0, 24'h0000C0, 8'd1},  // R1
    '{1'b1, 2'd1, 5'h14, 32'h0000_0003, 32'h0, 24'hFF00C0, 24'h0000C0, 8'd7},  // R7
    '{1'b0, 2'd1, 5'h14, 32'h0,         32'h0000_0003, 24'hFF00C0, 24'h0000C0, 8'd7},  // R7
    '{1'b0, 2'd2, 5'h00, 32'h0,         32'h0000_0000, 24'hFF00C0, 24'h0000C0, 8'd5},  // R5
    '{1'b1, 2'd0, 5'h08, 32'hFFFF_FFFF, 32'h0, 24'hFF00C0, 24'h0000C0, 8'd5},  // R5
    '{1'b0, 2'd0, 5'h08, 32'h0,         32'h0000_0000, 24'hFF00C0, 24'h0000C0, 8'd5}   // R5
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] win, input logic [4:0] addr,
                          input logic [31:0] data);
    @(negedge clk);
    busWinSel = win; busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [1:0] win, input logic [4:0] addr,
                         output logic [31:0] data);
    @(negedge clk);
    busWinSel = win; busAddr = addr; busWrEn = 1'b0;
    #2;
    data = busRdData;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL R11 watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;

    // R11: reset state
    settle(3);
    @(negedge clk);
    check("R11", "oe in reset", 32'(pinOe), 32'h0);
    check("R11", "irq in reset", 32'(irqOut), 32'h0);
    rstN = 1'b1;
    busRead(2'd0, 5'h00, rd); check("R11", "rise enable after reset", rd, 32'h0);
    busRead(2'd1, 5'h14, rd); check("R11", "mask after reset", rd, 32'h0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d", TBL[i].req);
      if (TBL[i].isWr) begin
        busWrite(TBL[i].win, TBL[i].addr, TBL[i].data);
      end else begin
        busRead(TBL[i].win, TBL[i].addr, rd);
        check(tag, $sformatf("row %0d read", i), rd, TBL[i].expRd);
      end
      #1;
      check(tag, $sformatf("row %0d oe", i), 32'(pinOe), 32'(TBL[i].expOe));
      check(tag, $sformatf("row %0d out", i), 32'(pinOut), 32'(TBL[i].expOut));
    end

    // rise=FF0005 fall=000006 mask=000003
    // R5 R7: input readback, causes latch while masked
    @(negedge clk); pinIn = 24'h5A5A5A;
    settle(5);
    busRead(2'd0, 5'h08, rd); check("R5", "synced pin levels", rd, 32'h005A_5A5A);
    busRead(2'd1, 5'h00, rd); check("R7", "masked pending", rd, 32'h0);
    check("R10", "irq with masked causes", 32'(irqOut), 32'h0);
    busWrite(2'd1, 5'h14, 32'hFFFF_FFFF);
    busRead(2'd1, 5'h00, rd); check("R7", "latched while masked", rd, 32'h005A_0000);
    check("R10", "irq when unmasked", 32'(irqOut), 32'h1);
    busWrite(2'd1, 5'h18, 32'hFFFF_FFFF);
    busRead(2'd1, 5'h00, rd); check("R8", "clear all", rd, 32'h0);
    check("R10", "irq after clear all", 32'(irqOut), 32'h0);

    // R6: falling edge on pin 1
    @(negedge clk); pinIn = 24'h5A5A58;
    settle(5);
    busRead(2'd1, 5'h00, rd); check("R6", "fall edge pin1", rd, 32'h2);
    busWrite(2'd1, 5'h18, 32'h1);
    busRead(2'd1, 5'h00, rd); check("R8", "partial clear keeps bit1", rd, 32'h2);
    busWrite(2'd1, 5'h18, 32'h2);
    busRead(2'd1, 5'h00, rd); check("R8", "bit1 cleared", rd, 32'h0);

    // R6: pin 2 reports both edges
    @(negedge clk); pinIn = 24'h5A5A5C;
    settle(5);
    busRead(2'd1, 5'h00, rd); check("R6", "pin2 rise", rd, 32'h4);
    busWrite(2'd1, 5'h18, 32'h4);
    @(negedge clk); pinIn = 24'h5A5A58;
    settle(5);
    busRead(2'd1, 5'h00, rd); check("R6", "pin2 fall", rd, 32'h4);
    busWrite(2'd1, 5'h18, 32'h4);

    // R6: no level sensing, disabled fall edge ignored
    @(negedge clk); pinIn = 24'h5A5A59;
    settle(5);
    busRead(2'd1, 5'h00, rd); check("R6", "pin0 rise", rd, 32'h1);
    busWrite(2'd1, 5'h18, 32'h1);
    settle(6);
    busRead(2'd1, 5'h00, rd); check("R6", "steady high sets nothing", rd, 32'h0);
    @(negedge clk); pinIn = 24'h5A5A58;
    settle(5);
    busRead(2'd1, 5'h00, rd); check("R6", "disabled fall edge", rd, 32'h0);

    // R9: clear lands in the cycle the edge is detected
    @(negedge clk); pinIn = 24'h5A5A59;
    @(posedge clk);
    @(posedge clk);
    busWrite(2'd1, 5'h18, 32'h1);
    busRead(2'd1, 5'h00, rd); check("R9", "edge beats clear", rd, 32'h1);

    // R10: mask gates the interrupt
    busWrite(2'd1, 5'h14, 32'h0);
    #1; check("R10", "irq masked off", 32'(irqOut), 32'h0);
    busRead(2'd1, 5'h00, rd); check("R7", "pending masked off", rd, 32'h0);
    busWrite(2'd1, 5'h14, 32'h1);
    #1; check("R10", "irq unmasked again", 32'(irqOut), 32'h1);
    busWrite(2'd1, 5'h18, 32'h1);
    #1; check("R10", "irq after clear", 32'(irqOut), 32'h0);

    // R11: reset mid-run
    @(negedge clk); busWrite(2'd1, 5'h14, 32'hFFFF_FFFF);
    @(negedge clk); rstN = 1'b0;
    #2;
    check("R11", "oe cleared", 32'(pinOe), 32'h0);
    check("R11", "out cleared", 32'(pinOut), 32'h0);
    check("R11", "irq cleared", 32'(irqOut), 32'h0);
    settle(2);
    @(negedge clk); rstN = 1'b1;
    settle(4);
    busRead(2'd0, 5'h04, rd); check("R11", "fall enable cleared", rd, 32'h0);
    busRead(2'd1, 5'h14, rd); check("R11", "mask cleared", rd, 32'h0);
    busWrite(2'd1, 5'h14, 32'hFFFF_FFFF);
    busRead(2'd1, 5'h00, rd); check("R11", "causes cleared", rd, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule